// File: doc/BRIEF.md
# Aliased Multi-Width Vector Register File

This block holds a set of 512-bit vector registers. Every register can be reached through three views: the whole 512 bits, its lower 256 bits, or its lower 128 bits. All three views share one storage array, so a narrow view is a window onto the low end of the same register and not a separate copy. There are two combinational read ports and one write port. Each port carries a register index and a 2-bit view code, and the write port also has an enable.

A mode input sets how many registers can be addressed. In wide mode all 32 can be used. In legacy mode only the lowest 8 can be used. An access that is illegal has no effect and raises an error flag. An access is illegal when its index is outside the current mode's range, or when its view code is the reserved value. A read that hits a register being written in the same cycle sees the new contents, so a consumer never gets stale data.

Top module: `vecreg_alias_file`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero.
- R2: A legal write with view code 2 (512 bits) stores all 512 data bits at the rising edge. A later 512-bit read returns them unchanged.
- R3: A read with view code 1 returns bits 255:0 of the selected register, with bits 511:256 of the output at zero.
- R4: A read with view code 0 returns bits 127:0 of the selected register, with bits 511:128 of the output at zero.
- R5: A write with view code 0 or 1 stores the low 128 or 256 data bits and clears every register bit above that width.
- R6: With `mode_wide` high, indices 0 to 31 are all addressable and independent.
- R7: With `mode_wide` low, an index of 8 or more causes the following: the port's error flag goes high, a write is suppressed, and a read returns zero.
- R8: View code 3 is reserved. It raises the port's error flag, suppresses the write and returns zero on a read.
- R9: A read of the index being legally written in the same cycle returns the new data, shaped by both the write view and the read view.
- R10: The two read ports are independent. Each one returns its own register and view in the same cycle.
- R11: `wr_err` is high only while `wr_en` is high and the write is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_wide | input | 1 | 1: 32 registers addressable; 0: 8 registers addressable |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_view | input | 2 | Write view: 0=128, 1=256, 2=512, 3=reserved |
| wr_data | input | 512 | Write data (low bits used for narrow views) |
| wr_err | output | 1 | Illegal write request, write dropped |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view code |
| rd0_data | output | 512 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal access |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view code |
| rd1_data | output | 512 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal access |

## Verification
A write and a read of the same register can land in the same cycle. The forwarding path then has to apply the write's zero-extension and the read's view cut together. The bench provokes this by holding a write and reads of the same index at once, for full and narrow writes and for mixed read views. It judges each read output before the edge against the data being written, not against the old contents. It also overlaps a forwarding collision with an out-of-range index in legacy mode, where the error has to win and the read must stay zero.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int VEC_W = 512;
  localparam int HALF_W = VEC_W / 2;
  localparam int QUART_W = VEC_W / 4;

  localparam logic [1:0] VIEW_Q = 2'd0;
  localparam logic [1:0] VIEW_H = 2'd1;
  localparam logic [1:0] VIEW_F = 2'd2;
  localparam logic [1:0] VIEW_RSV = 2'd3;

  function automatic logic view_is_legal(input logic [1:0] v);
    return v != VIEW_RSV;
  endfunction

  // Keep the low bits that the view covers and force the rest to zero.
  function automatic logic [VEC_W-1:0] view_fit(input logic [VEC_W-1:0] d,
                                               input logic [1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    case (v)
      VIEW_Q:  r[QUART_W-1:0] = d[QUART_W-1:0];
      VIEW_H:  r[HALF_W-1:0] = d[HALF_W-1:0];
      VIEW_F:  r = d;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vrf_access_check.sv
module vrf_access_check
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LEGACY_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       view_i,
  input  logic             mode_wide_i,
  output logic             ok_o
);
  logic idx_in_range;
  logic view_ok;

  always_comb begin
    view_ok = view_is_legal(view_i);
    if (mode_wide_i) idx_in_range = (int'(idx_i) < NUM_REGS);
    else             idx_in_range = (int'(idx_i) < LEGACY_REGS);
    ok_o = idx_in_range && view_ok;
  end
endmodule

// File: rtl/vrf_store.sv
module vrf_store
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic [VEC_W-1:0] regs_o [NUM_REGS]
);
  logic [VEC_W-1:0] bank [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (we_i) begin
      bank[widx_i] <= wdata_i;
    end
  end

  assign regs_o = bank;

  // Observation wires for the checks below.
  logic             bank_all_zero;
  logic             rst_q = 1'b0;
  logic             we_q;
  logic [IDX_W-1:0] widx_q;
  logic [VEC_W-1:0] wdata_q;

  always_comb begin
    bank_all_zero = 1'b1;
    for (int i = 0; i < NUM_REGS; i++)
      if (bank[i] != '0) bank_all_zero = 1'b0;
  end

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    we_q    <= rst ? 1'b0 : we_i;
    widx_q  <= widx_i;
    wdata_q <= wdata_i;
  end

  // R1: the cycle after a reset edge, nothing remains in the bank
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst_q |-> bank_all_zero);

  // R2: an accepted write is visible in the bank one edge later
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we_q |-> bank[widx_q] == wdata_q);
endmodule

// File: rtl/vrf_read_port.sv
module vrf_read_port
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       view_i,
  input  logic             ok_i,
  input  logic [VEC_W-1:0] regs_i [NUM_REGS],
  input  logic             byp_en_i,
  input  logic [IDX_W-1:0] byp_idx_i,
  input  logic [VEC_W-1:0] byp_data_i,
  output logic [VEC_W-1:0] data_o,
  output logic             hit_o
);
  logic [VEC_W-1:0] src;

  always_comb begin
    hit_o  = ok_i && byp_en_i && (byp_idx_i == idx_i);
    src    = hit_o ? byp_data_i : regs_i[idx_i];
    data_o = ok_i ? view_fit(src, view_i) : '0;
  end

  // R7 / R8: a rejected read drives nothing but zeros
  assert_err_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !ok_i |-> data_o == '0);

  // R3 / R4: narrow views never leak upper bits
  assert_view_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (view_i != VIEW_F) |-> data_o[VEC_W-1:HALF_W] == '0);
endmodule

// File: rtl/vecreg_alias_file.sv
module vecreg_alias_file
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LEGACY_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int N_RD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wide,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_view,
  input  logic [VEC_W-1:0] wr_data,
  output logic             wr_err,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_view,
  output logic [VEC_W-1:0] rd0_data,
  output logic             rd0_err,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_view,
  output logic [VEC_W-1:0] rd1_data,
  output logic             rd1_err
);
  logic             wr_ok;
  logic             wr_commit;
  logic [VEC_W-1:0] wr_fit;
  logic [VEC_W-1:0] regs [NUM_REGS];

  vrf_access_check #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_wchk (
    .idx_i(wr_idx), .view_i(wr_view), .mode_wide_i(mode_wide), .ok_o(wr_ok)
  );

  assign wr_commit = wr_en && wr_ok;
  assign wr_err    = wr_en && !wr_ok;
  assign wr_fit    = view_fit(wr_data, wr_view);

  vrf_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst), .we_i(wr_commit), .widx_i(wr_idx),
    .wdata_i(wr_fit), .regs_o(regs)
  );

  logic [IDX_W-1:0] rd_idx  [N_RD];
  logic [1:0]       rd_view [N_RD];
  logic [VEC_W-1:0] rd_data [N_RD];
  logic             rd_ok   [N_RD];
  logic             rd_hit  [N_RD];

  assign rd_idx[0]  = rd0_idx;
  assign rd_view[0] = rd0_view;
  assign rd_idx[1]  = rd1_idx;
  assign rd_view[1] = rd1_view;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    vrf_access_check #(.NUM_REGS(NUM_REGS), .LEGACY_REGS(LEGACY_REGS)) u_chk (
      .idx_i(rd_idx[p]), .view_i(rd_view[p]), .mode_wide_i(mode_wide),
      .ok_o(rd_ok[p])
    );
    vrf_read_port #(.NUM_REGS(NUM_REGS)) u_port (
      .clk(clk), .rst(rst), .idx_i(rd_idx[p]), .view_i(rd_view[p]),
      .ok_i(rd_ok[p]), .regs_i(regs), .byp_en_i(wr_commit),
      .byp_idx_i(wr_idx), .byp_data_i(wr_fit),
      .data_o(rd_data[p]), .hit_o(rd_hit[p])
    );
  end

  assign rd0_data = rd_data[0];
  assign rd0_err  = !rd_ok[0];
  assign rd1_data = rd_data[1];
  assign rd1_err  = !rd_ok[1];

  // R11: no error without a request
  assert_wr_err_needs_en_R11: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> wr_en);

  // R7: legacy mode refuses high indices
  assert_legacy_range_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_wide && wr_en && int'(wr_idx) >= LEGACY_REGS) |-> wr_err);

  // R8: reserved view is always refused
  assert_reserved_view_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_view == VIEW_RSV) |-> wr_err);

  // R9: a forwarded value is the value the bank holds one cycle later
  assert_bypass_matches_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_hit[0] ##1 (!wr_en && $stable(rd0_idx) && $stable(rd0_view)
                    && $stable(mode_wide)))
    |-> rd0_data == $past(rd0_data));
endmodule

// File: tb/vecreg_alias_file_tb_top.sv
`timescale 1ns/1ps
module vecreg_alias_file_tb_top;
  localparam int W = 512;

  logic         clk = 1'b0;
  logic         rst;
  logic         mode_wide;
  logic         wr_en;
  logic [4:0]   wr_idx;
  logic [1:0]   wr_view;
  logic [W-1:0] wr_data;
  logic         wr_err;
  logic [4:0]   rd0_idx, rd1_idx;
  logic [1:0]   rd0_view, rd1_view;
  logic [W-1:0] rd0_data, rd1_data;
  logic         rd0_err, rd1_err;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [W-1:0] model [32];

  always #5 clk = ~clk;

  vecreg_alias_file dut_i (
    .clk(clk), .rst(rst), .mode_wide(mode_wide),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
    .wr_err(wr_err),
    .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err)
  );

  // Expected shaping by view code: 0 -> low 128, 1 -> low 256, 2 -> all, 3 -> none
  function automatic logic [W-1:0] shape(input logic [W-1:0] d, input logic [1:0] v);
    logic [W-1:0] keep;
    if (v == 2'd0)      keep = {{(W-128){1'b0}}, {128{1'b1}}};
    else if (v == 2'd1) keep = {{(W-256){1'b0}}, {256{1'b1}}};
    else if (v == 2'd2) keep = {W{1'b1}};
    else                keep = '0;
    return d & keep;
  endfunction

  function automatic logic [W-1:0] pat(input logic [31:0] seed);
    logic [W-1:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = seed * 32'h9E37_79B9 + 32'(i) * 32'h0101_0103;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    chk(act === exp, req, {{(W-1){1'b0}}, act}, {{(W-1){1'b0}}, exp});
  endtask

  // Set both read ports, then sample away from the edge.
  task automatic set_rd(input logic [4:0] i0, input logic [1:0] v0,
                        input logic [4:0] i1, input logic [1:0] v1);
    rd0_idx = i0; rd0_view = v0; rd1_idx = i1; rd1_view = v1;
    #1;
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [1:0] v,
                          input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_view = v; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (v != 2'd3 && (mode_wide || idx < 5'd8)) model[idx] = shape(d, v);
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < 32; i++) begin
      set_rd(5'(i), 2'd2, 5'(31 - i), 2'd0);
      chk(rd0_data === '0, "R1 reset rd0", rd0_data, '0);
      chk(rd1_data === '0, "R1 reset rd1", rd1_data, '0);
    end
    chk_bit("R11 idle wr_err", wr_err, 1'b0);
  endtask

  task automatic t_full_write;
    do_write(5'd5, 2'd2, pat(1));
    do_write(5'd31, 2'd2, pat(2));
    do_write(5'd0, 2'd2, pat(3));
    set_rd(5'd5, 2'd2, 5'd31, 2'd2);
    chk(rd0_data === pat(1), "R2 full reg5", rd0_data, pat(1));
    chk(rd1_data === pat(2), "R6 full reg31", rd1_data, pat(2));
    set_rd(5'd0, 2'd2, 5'd16, 2'd2);
    chk(rd0_data === pat(3), "R6 full reg0", rd0_data, pat(3));
    chk(rd1_data === '0, "R6 reg16 untouched", rd1_data, '0);
  endtask

  task automatic t_view_reads;
    set_rd(5'd5, 2'd1, 5'd5, 2'd0);
    chk(rd0_data === shape(pat(1), 2'd1), "R3 256 view", rd0_data, shape(pat(1), 2'd1));
    chk(rd1_data === shape(pat(1), 2'd0), "R4 128 view", rd1_data, shape(pat(1), 2'd0));
    chk_bit("R3 no err", rd0_err, 1'b0);
  endtask

  task automatic t_two_ports;
    set_rd(5'd31, 2'd1, 5'd0, 2'd2);
    chk(rd0_data === shape(pat(2), 2'd1), "R10 port0", rd0_data, shape(pat(2), 2'd1));
    chk(rd1_data === pat(3), "R10 port1", rd1_data, pat(3));
  endtask

  task automatic t_narrow_write;
    do_write(5'd5, 2'd0, pat(4));
    set_rd(5'd5, 2'd2, 5'd5, 2'd1);
    chk(rd0_data === shape(pat(4), 2'd0), "R5 128 write clears upper", rd0_data,
        shape(pat(4), 2'd0));
    chk(rd1_data === shape(pat(4), 2'd0), "R5 128 write via 256 view", rd1_data,
        shape(pat(4), 2'd0));
    do_write(5'd31, 2'd1, pat(5));
    set_rd(5'd31, 2'd2, 5'd0, 2'd2);
    chk(rd0_data === shape(pat(5), 2'd1), "R5 256 write clears upper", rd0_data,
        shape(pat(5), 2'd1));
  endtask

  task automatic t_bypass;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_view = 2'd2; wr_data = pat(6);
    set_rd(5'd9, 2'd2, 5'd9, 2'd0);
    chk(rd0_data === pat(6), "R9 bypass full", rd0_data, pat(6));
    chk(rd1_data === shape(pat(6), 2'd0), "R9 bypass 128 read", rd1_data,
        shape(pat(6), 2'd0));
    @(negedge clk);
    model[9] = pat(6);
    wr_idx = 5'd9; wr_view = 2'd1; wr_data = pat(7);
    set_rd(5'd9, 2'd2, 5'd0, 2'd2);
    chk(rd0_data === shape(pat(7), 2'd1), "R9 bypass narrow write", rd0_data,
        shape(pat(7), 2'd1));
    chk(rd1_data === pat(3), "R9 other port unaffected", rd1_data, pat(3));
    @(negedge clk);
    wr_en = 1'b0;
    model[9] = shape(pat(7), 2'd1);
    set_rd(5'd9, 2'd2, 5'd9, 2'd2);
    chk(rd0_data === model[9], "R9 stored after bypass", rd0_data, model[9]);
  endtask

  task automatic t_legacy_mode;
    do_write(5'd12, 2'd2, pat(8));
    @(negedge clk);
    mode_wide = 1'b0;
    set_rd(5'd12, 2'd2, 5'd5, 2'd2);
    chk_bit("R7 rd err high idx", rd0_err, 1'b1);
    chk(rd0_data === '0, "R7 rd zero high idx", rd0_data, '0);
    chk(rd1_data === model[5], "R7 low idx still ok", rd1_data, model[5]);
    wr_en = 1'b1; wr_idx = 5'd12; wr_view = 2'd2; wr_data = pat(9);
    #1;
    chk_bit("R7 wr err high idx", wr_err, 1'b1);
    chk(rd0_data === '0, "R7 no bypass on bad idx", rd0_data, '0);
    @(negedge clk);
    wr_en = 1'b0;
    do_write(5'd7, 2'd2, pat(10));
    set_rd(5'd7, 2'd2, 5'd7, 2'd0);
    chk(rd0_data === pat(10), "R7 idx7 usable", rd0_data, pat(10));
    chk_bit("R7 idx7 no err", rd0_err, 1'b0);
    @(negedge clk);
    mode_wide = 1'b1;
    set_rd(5'd12, 2'd2, 5'd12, 2'd2);
    chk(rd0_data === pat(8), "R7 write suppressed", rd0_data, pat(8));
  endtask

  task automatic t_reserved_view;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd0; wr_view = 2'd3; wr_data = pat(11);
    set_rd(5'd0, 2'd3, 5'd0, 2'd2);
    chk_bit("R8 wr err", wr_err, 1'b1);
    chk_bit("R8 rd err", rd0_err, 1'b1);
    chk(rd0_data === '0, "R8 rd zero", rd0_data, '0);
    @(negedge clk);
    wr_en = 1'b0;
    set_rd(5'd0, 2'd2, 5'd0, 2'd2);
    chk(rd0_data === pat(3), "R8 write suppressed", rd0_data, pat(3));
  endtask

  task automatic t_err_gating;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 5'd20; wr_view = 2'd3; mode_wide = 1'b0;
    #1;
    chk_bit("R11 no err without en", wr_err, 1'b0);
    @(negedge clk);
    mode_wide = 1'b1;
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_rd(5'd12, 2'd2, 5'd31, 2'd2);
    chk(rd0_data === '0, "R1 re-reset reg12", rd0_data, '0);
    chk(rd1_data === '0, "R1 re-reset reg31", rd1_data, '0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    rst = 1'b1; mode_wide = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_view = 2'd2;
    wr_data = '0; rd0_idx = '0; rd1_idx = '0; rd0_view = 2'd2; rd1_view = 2'd2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_full_write();
    t_view_reads();
    t_two_ports();
    t_narrow_write();
    t_bypass();
    t_legacy_mode();
    t_reserved_view();
    t_err_gating();
    t_reset_again();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule